// File: doc/BRIEF.md
# Multi-mode RAM sweep address sequencer

This block produces the read address for the waveform or tuning-word RAM of a direct digital synthesizer. Each of four segment words holds a beginning address, a final address, a ramp rate and a mode. The profile select pins choose which word is active. A reloadable down-counter sets how many clock cycles the address rests on each location before it moves by one.

The modes are a single ramp up that stops at the final address, a ramp whose direction a profile pin controls, an automatic triangle sweep and an automatic sawtooth sweep. A sweep restarts from the beginning address on an update strobe or on a change of the profile pins. A single ramp up can end by clearing the phase accumulator instead of holding at the final address. A done flag shows that a single ramp has finished.

Top module: `sweep_addr_seq`

## Requirements
- R1: When ram_en_i is low, or the selected word's mode is 3'b000 or an unused code (3'b101 to 3'b111), addr_o follows the beginning address of the word chosen by profile_i one clock later. acc_clr_o and done_o are low in this case.
- R2: A sweep starts on the clock edge that samples update_i high, or that samples profile_i different from its value one cycle earlier (except in mode 3'b010). addr_o then equals the beginning address and advances by one every `rate` cycles. A rate of 0 acts as 1.
- R3: In mode 3'b001 the address stops at the final address. One full rate period after the address reaches the final address, done_o rises. done_o stays high and the address stays put until the next sweep start.
- R4: With no_dwell_i high in mode 3'b001, acc_clr_o rises together with done_o. It stays high until the next sweep start clears it.
- R5: Mode 3'b010 is selected when word 0 holds that mode, whatever profile_i is. Only word 0 is used. profile_i[0]=1 ramps up and saturates at the final address. profile_i[0]=0 ramps down and saturates at the beginning address. no_dwell_i and profile_i[1] have no effect.
- R6: In mode 3'b010, a falling edge on profile_i[0] decrements the address on the next clock edge, unless the address is already at the beginning address. It also reloads the rate timer, so the next step comes `rate` cycles later.
- R7: In mode 3'b010, changes of profile_i never restart the sweep. Only update_i restarts it.
- R8: In mode 3'b011 the address goes from the beginning address to the final address, rests there for one rate period, and steps back down. It rests one period at the beginning address and climbs again. This repeats indefinitely.
- R9: In mode 3'b100, the address goes to the beginning address at the end of the rate period spent at the final address. It then ramps up again, indefinitely.
- R10: When the beginning and final addresses are equal, the address stays constant in every mode and never reverses.
- R11: In modes 3'b011 and 3'b100, a change of profile_i selects the new word and restarts from that word's beginning address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ram_en_i | input | 1 | Enables sweeping |
| no_dwell_i | input | 1 | Clear the accumulator at the end of a single ramp |
| seg_begin_i | input | NP*AW | Beginning address of each segment word |
| seg_final_i | input | NP*AW | Final address of each segment word |
| seg_rate_i | input | NP*RW | Ramp rate of each segment word |
| seg_mode_i | input | NP*3 | Mode code of each segment word |
| profile_i | input | PW | Profile select / direction pins |
| update_i | input | 1 | Restart strobe |
| addr_o | output | AW | RAM read address |
| acc_clr_o | output | 1 | Phase-accumulator clear request |
| done_o | output | 1 | Single ramp completed |

## Verification
The bench builds the block with a 6-bit address and a 4-bit ramp rate, keeping the four profiles. With a 6-bit address the all-ones address 63 can serve as a final address, so the sawtooth wrap is tested at the top of the address space. The 4-bit rate keeps the timer periods short enough that each sweep can be followed step by step. The same width reaches the zero-rate case, where the address moves every cycle.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [2:0] {
    MODE_HOLD = 3'b000,
    MODE_RAMP = 3'b001,
    MODE_EXT  = 3'b010,
    MODE_TRI  = 3'b011,
    MODE_SAW  = 3'b100
  } sweep_mode_e;

  function automatic sweep_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b001:  return MODE_RAMP;
      3'b010:  return MODE_EXT;
      3'b011:  return MODE_TRI;
      3'b100:  return MODE_SAW;
      default: return MODE_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/sweep_trigger.sv
module sweep_trigger #(
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] profile_i,
  input  logic          update_i,
  input  logic          ext_i,
  output logic          start_o,
  output logic          fall_o
);
  logic [PW-1:0] prof_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prof_q <= '0;
    else         prof_q <= profile_i;

  // profile pins are a direction control, not a trigger, in external mode
  assign start_o = update_i || ((profile_i != prof_q) && !ext_i);
  assign fall_o  = prof_q[0] && !profile_i[0];
endmodule

// File: rtl/sweep_ramp_timer.sv
module sweep_ramp_timer #(
  parameter int RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [RW-1:0] rate_i,
  output logic          tick_o
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] rate_eff;

  assign rate_eff = (rate_i == '0) ? RW'(1) : rate_i;
  assign tick_o   = (cnt_q == RW'(1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cnt_q <= RW'(1);
    else if (load_i || tick_o)  cnt_q <= rate_eff;
    else                        cnt_q <= cnt_q - 1'b1;

  assert_cnt_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !tick_o |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sweep_addr_core.sv
module sweep_addr_core
  import sweep_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  sweep_mode_e   mode_i,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          fall_i,
  input  logic          dir_pin_i,
  input  logic          no_dwell_i,
  input  logic [AW-1:0] begin_i,
  input  logic [AW-1:0] final_i,
  output logic [AW-1:0] addr_o,
  output logic          clr_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q;
  logic          up_q, clr_q, done_q;
  logic          at_begin, at_final, flat;

  assign at_begin = (addr_q == begin_i);
  assign at_final = (addr_q == final_i);
  assign flat     = (begin_i == final_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q <= '0;
      up_q   <= 1'b1;
      clr_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!active_i || start_i) begin
      addr_q <= begin_i;
      up_q   <= 1'b1;
      clr_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (mode_i == MODE_EXT && fall_i) begin
      if (!at_begin) addr_q <= addr_q - 1'b1;
    end else if (tick_i) begin
      case (mode_i)
        MODE_RAMP: begin
          if (!at_final) addr_q <= addr_q + 1'b1;
          else begin
            done_q <= 1'b1;
            if (no_dwell_i) clr_q <= 1'b1;
          end
        end
        MODE_EXT: begin
          if (dir_pin_i && !at_final)       addr_q <= addr_q + 1'b1;
          else if (!dir_pin_i && !at_begin) addr_q <= addr_q - 1'b1;
        end
        MODE_TRI: begin
          if (!flat) begin
            if (up_q) begin
              if (at_final) begin
                up_q   <= 1'b0;
                addr_q <= addr_q - 1'b1;
              end else addr_q <= addr_q + 1'b1;
            end else begin
              if (at_begin) begin
                up_q   <= 1'b1;
                addr_q <= addr_q + 1'b1;
              end else addr_q <= addr_q - 1'b1;
            end
          end
        end
        MODE_SAW: begin
          if (at_final) addr_q <= begin_i;
          else          addr_q <= addr_q + 1'b1;
        end
        default: ;
      endcase
    end

  assign addr_o = addr_q;
  assign clr_o  = clr_q;
  assign done_o = done_q;

  assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i && !tick_i && !fall_i |=> $stable(addr_q));
  assert_ramp_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i && tick_i && mode_i == MODE_RAMP && !at_final
    |=> addr_q == $past(addr_q) + 1'b1);
  assert_clr_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q && active_i && !start_i |=> clr_q);
  assert_clr_with_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> done_q);
  assert_fall_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i && mode_i == MODE_EXT && fall_i && !at_begin
    |=> addr_q == $past(addr_q) - 1'b1);
  assert_tri_turn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i && tick_i && mode_i == MODE_TRI && up_q && at_final && !flat
    |=> addr_q == $past(addr_q) - 1'b1);
  assert_saw_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i && tick_i && mode_i == MODE_SAW && at_final
    |=> addr_q == $past(begin_i));
  assert_flat_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i && flat && at_begin |=> addr_q == $past(addr_q));
endmodule

// File: rtl/sweep_addr_seq.sv
module sweep_addr_seq
  import sweep_pkg::*;
#(
  parameter  int AW = 10,
  parameter  int RW = 16,
  parameter  int PW = 2,
  localparam int NP = 1 << PW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ram_en_i,
  input  logic                   no_dwell_i,
  input  logic [NP-1:0][AW-1:0]  seg_begin_i,
  input  logic [NP-1:0][AW-1:0]  seg_final_i,
  input  logic [NP-1:0][RW-1:0]  seg_rate_i,
  input  logic [NP-1:0][2:0]     seg_mode_i,
  input  logic [PW-1:0]          profile_i,
  input  logic                   update_i,
  output logic [AW-1:0]          addr_o,
  output logic                   acc_clr_o,
  output logic                   done_o
);
  sweep_mode_e   word_mode [NP];
  logic          ext_sel, active, start, fall, tick, load;
  logic [PW-1:0] sel;
  sweep_mode_e   mode;

  for (genvar g = 0; g < NP; g++) begin : g_decode
    assign word_mode[g] = decode_mode(seg_mode_i[g]);
  end

  // word 0 in external mode overrides the profile pins as a selector
  assign ext_sel = ram_en_i && (word_mode[0] == MODE_EXT);
  assign sel     = ext_sel ? '0 : profile_i;
  assign mode    = word_mode[sel];
  assign active  = ram_en_i && (mode != MODE_HOLD);

  sweep_trigger #(.PW(PW)) u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .profile_i(profile_i),
    .update_i (update_i),
    .ext_i    (ext_sel),
    .start_o  (start),
    .fall_o   (fall)
  );

  assign load = !active || start || (mode == MODE_EXT && fall);

  sweep_ramp_timer #(.RW(RW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .rate_i(seg_rate_i[sel]),
    .tick_o(tick)
  );

  sweep_addr_core #(.AW(AW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .mode_i    (mode),
    .start_i   (start),
    .tick_i    (tick),
    .fall_i    (fall),
    .dir_pin_i (profile_i[0]),
    .no_dwell_i(no_dwell_i),
    .begin_i   (seg_begin_i[sel]),
    .final_i   (seg_final_i[sel]),
    .addr_o    (addr_o),
    .clr_o     (acc_clr_o),
    .done_o    (done_o)
  );

  assert_ext_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && mode == MODE_EXT && !update_i && !tick && !fall |=> $stable(addr_o));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !acc_clr_o && !done_o);
endmodule

// File: tb/sweep_addr_seq_tb_top.sv
module sweep_addr_seq_tb_top;
  localparam int AW = 6;
  localparam int RW = 4;
  localparam int PW = 2;
  localparam int NP = 1 << PW;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  ram_en_i = 1'b0;
  logic                  no_dwell_i = 1'b0;
  logic [NP-1:0][AW-1:0] seg_begin_i = '0;
  logic [NP-1:0][AW-1:0] seg_final_i = '0;
  logic [NP-1:0][RW-1:0] seg_rate_i = '0;
  logic [NP-1:0][2:0]    seg_mode_i = '0;
  logic [PW-1:0]         profile_i = '0;
  logic                  update_i = 1'b0;
  logic [AW-1:0]         addr_o;
  logic                  acc_clr_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  sweep_addr_seq #(.AW(AW), .RW(RW), .PW(PW)) dut_i (
    .clk_i, .rst_ni, .ram_en_i, .no_dwell_i, .seg_begin_i, .seg_final_i,
    .seg_rate_i, .seg_mode_i, .profile_i, .update_i, .addr_o, .acc_clr_o, .done_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_word(input int i, input int b, input int f, input int r, input int m);
    seg_begin_i[i] = AW'(b);
    seg_final_i[i] = AW'(f);
    seg_rate_i[i]  = RW'(r);
    seg_mode_i[i]  = 3'(m);
  endtask

  task automatic pulse_update();
    update_i = 1'b1;
    step(1);
    update_i = 1'b0;
  endtask

  task automatic set_prof(input int p);
    profile_i = PW'(p);
    step(1);
  endtask

  task automatic t_reset();
    chk("R1 reset addr", addr_o, 0);
    chk("R1 reset clr", acc_clr_o, 0);
    chk("R1 reset done", done_o, 0);
    set_word(0, 5, 9, 2, 0);
    rst_ni = 1'b1;
    step(2);
    chk("R1 disabled follows begin", addr_o, 5);
  endtask

  task automatic t_hold();
    set_word(1, 20, 22, 3, 1);
    set_prof(1);
    chk("R1 disabled word1", addr_o, 20);
    seg_begin_i[1] = AW'(25);
    step(1);
    chk("R1 begin tracked", addr_o, 25);
    seg_mode_i[1] = 3'b000;
    ram_en_i = 1'b1;
    step(5);
    chk("R1 mode hold", addr_o, 25);
    seg_mode_i[1] = 3'b110;
    step(5);
    chk("R1 unused code holds", addr_o, 25);
    chk("R1 unused code done", done_o, 0);
  endtask

  task automatic t_ramp();
    set_word(1, 10, 13, 3, 1);
    no_dwell_i = 1'b0;
    pulse_update();
    chk("R2 start addr", addr_o, 10);
    step(2);
    chk("R2 no step before rate", addr_o, 10);
    step(1);
    chk("R2 step after rate", addr_o, 11);
    step(6);
    chk("R3 reach final", addr_o, 13);
    step(2);
    chk("R3 done not yet", done_o, 0);
    step(1);
    chk("R3 done after dwell", done_o, 1);
    chk("R3 no clear without no-dwell", acc_clr_o, 0);
    step(8);
    chk("R3 holds final", addr_o, 13);
    chk("R3 done holds", done_o, 1);
  endtask

  task automatic t_no_dwell();
    no_dwell_i = 1'b1;
    pulse_update();
    chk("R3 restart addr", addr_o, 10);
    chk("R3 restart done", done_o, 0);
    step(11);
    chk("R4 clear not yet", acc_clr_o, 0);
    step(1);
    chk("R4 clear asserted", acc_clr_o, 1);
    chk("R4 done with clear", done_o, 1);
    step(10);
    chk("R4 clear sticky", acc_clr_o, 1);
    chk("R4 address at final", addr_o, 13);
    pulse_update();
    chk("R4 clear released", acc_clr_o, 0);
    chk("R4 restart addr", addr_o, 10);
    no_dwell_i = 1'b0;
  endtask

  task automatic t_rate0();
    set_word(1, 20, 22, 0, 1);
    pulse_update();
    chk("R2 rate0 start", addr_o, 20);
    step(1);
    chk("R2 rate0 step1", addr_o, 21);
    step(1);
    chk("R2 rate0 step2", addr_o, 22);
    step(1);
    chk("R3 rate0 done", done_o, 1);
  endtask

  task automatic t_ext();
    set_word(0, 30, 33, 4, 2);
    set_word(2, 1, 2, 1, 1);
    no_dwell_i = 1'b1;
    profile_i = 2'b01;
    pulse_update();
    chk("R5 ext start", addr_o, 30);
    step(4);
    chk("R5 ext up", addr_o, 31);
    step(8);
    chk("R5 ext final", addr_o, 33);
    step(8);
    chk("R5 ext saturate high", addr_o, 33);
    chk("R5 no-dwell ignored", acc_clr_o, 0);
    chk("R5 no done", done_o, 0);
    set_prof(2'b11);
    chk("R7 bit1 change no restart", addr_o, 33);
    set_prof(2'b10);
    chk("R6 fall decrements at once", addr_o, 32);
    step(3);
    chk("R6 timer reloaded", addr_o, 32);
    step(1);
    chk("R6 next down step", addr_o, 31);
    step(4);
    chk("R5 down to begin", addr_o, 30);
    step(8);
    chk("R5 saturate low", addr_o, 30);
    set_prof(2'b11);
    set_prof(2'b10);
    chk("R6 fall at begin holds", addr_o, 30);
    profile_i = 2'b11;
    pulse_update();
    chk("R7 update restarts", addr_o, 30);
    step(4);
    chk("R7 climbs after update", addr_o, 31);
    no_dwell_i = 1'b0;
  endtask

  task automatic t_tri();
    int exp_seq[7] = '{40, 41, 42, 41, 40, 41, 42};
    seg_mode_i[0] = 3'b000;
    set_word(2, 40, 42, 2, 3);
    set_prof(0);
    set_prof(2);
    for (int k = 0; k < 7; k++) begin
      chk("R8 triangle", addr_o, exp_seq[k]);
      step(2);
    end
  endtask

  task automatic t_saw();
    int exp_seq[7] = '{60, 61, 62, 63, 60, 61, 62};
    set_word(3, 60, 63, 2, 4);
    step(1);
    set_prof(3);
    chk("R11 switch restarts", addr_o, 60);
    for (int k = 0; k < 7; k++) begin
      chk("R9 sawtooth", addr_o, exp_seq[k]);
      step(2);
    end
  endtask

  task automatic t_flat();
    int bad = 0;
    set_word(1, 50, 50, 1, 3);
    set_prof(1);
    chk("R11 new word", addr_o, 50);
    for (int k = 0; k < 10; k++) begin
      if (addr_o != AW'(50)) bad++;
      step(1);
    end
    chk("R10 flat triangle constant", bad, 0);
    seg_mode_i[1] = 3'b100;
    pulse_update();
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      if (addr_o != AW'(50)) bad++;
      step(1);
    end
    chk("R10 flat sawtooth constant", bad, 0);
  endtask

  initial begin
    step(2);
    t_reset();
    t_hold();
    t_ramp();
    t_no_dwell();
    t_rate0();
    t_ext();
    t_tri();
    t_saw();
    t_flat();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule